// File: doc/BRIEF.md
# Prescaled Compare Timer

This block is a register-mapped timer that counts a divided copy of the system clock. A power-of-two divider (2^0 up to 2^9) sets the tick rate. A 16-bit up-counter advances once per tick. Four compare registers watch the counter. Each compare register can raise a sticky event flag, and each can optionally force the counter back to zero to set a repeating period.

Software runs the timer through a plain synchronous bus. Single-shot task writes start the timer, halt it and zero it. Interrupt enables are changed through separate set and clear registers. One interrupt line is asserted while any enabled event flag is set. A typical use programs a period compare to P-1 with its auto-clear bit set. The other compares then mark points inside each P-tick cycle.

Read data is registered: a read presented before a clock edge returns its value after that edge. Registers are word addressed. The control registers are at addresses 0 to 7, the compare values at 8 to 11, and the event flags at 12 to 15.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter, the divider setting (address 4), the auto-clear mask (address 5), the enable mask, every compare value and every event flag read 0, the timer is halted, and `irq` is low.
- R2: With divider setting D, the counter advances once every 2^D running clock cycles. The first tick falls on the 2^D-th rising edge after the start edge.
- R3: A divider value above 9 written to address 4 is stored and read back as 9.
- R4: The divider phase returns to zero whenever the timer is halted or a zero task is written. A restarted timer therefore waits a full 2^D cycles before its first tick.
- R5: A write of 1 in bit 0 to address 0 starts counting and to address 1 halts it. While halted the counter holds its value, and address 3 reads the count.
- R6: A write of 1 in bit 0 to address 2 sets the counter to 0. This takes priority over a tick in the same cycle.
- R7: A tick on which the count equals compare n (address 8+n) sets flag n. If bit n of the auto-clear mask (address 5) is set, the counter becomes 0 on that tick instead of incrementing, so a compare value of P-1 gives a P-tick cycle.
- R8: A compare register holding 0 never raises its flag and never clears the counter.
- R9: Writing 1s to address 6 sets those enable bits, and writing 1s to address 7 clears them. Bits written as 0 change nothing, and both addresses read back the current enable mask.
- R10: Event flag n (address 12+n, bit 0) stays set until a write with bit 0 equal to 0 clears it.
- R11: `irq` is high exactly when some flag n and enable bit n are both set.
- R12: A compare match and a software clear of the same flag in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Word address |
| bus_wdata | input | CNT_W (16) | Write data |
| bus_rdata | output | CNT_W (16) | Read data, valid the cycle after the read |
| irq | output | 1 | Level interrupt from enabled event flags |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a hardware compare match and a software write that clears the same flag. The bench runs the counter at full rate with a known start edge and counts edges so that the flag write lands exactly on the matching tick; the flag must read back as set and the interrupt must stay high. The second pair is a zero task and a running tick on the same edge. The bench zeroes the counter while it runs and halts it one edge later; the count must read 1, not the old value plus two.

// File: rtl/cmp_tmr_pkg.sv
// Package: register identifiers and layout constants shared by the timer.
// Assumes word addressing with control registers below MATCH_BASE.
package cmp_tmr_pkg;

    // Control/task register identifiers (low address bits)
    typedef enum logic [2:0] {
        RG_RUN     = 3'd0,
        RG_HALT    = 3'd1,
        RG_ZERO    = 3'd2,
        RG_COUNT   = 3'd3,
        RG_DIV     = 3'd4,
        RG_AUTOCLR = 3'd5,
        RG_IEN_SET = 3'd6,
        RG_IEN_CLR = 3'd7
    } ctl_reg_e;

    localparam int MATCH_BASE = 8;

endpackage

// File: rtl/cmp_tmr_prescale.sv
// Module: power-of-two tick generator.
// Emits one tick every 2^div_i cycles while run_i is high; phase is reset
// when halted or on a zero task. Assumes div_i <= DIV_MAX.
module cmp_tmr_prescale #(
    parameter int DIV_MAX = 9,
    parameter int DIV_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam int PS_W = (DIV_MAX > 0) ? DIV_MAX : 1;

    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] mask;

    // Low div_i bits of the phase must all be ones for a tick
    assign mask   = ~({PS_W{1'b1}} << div_i);
    assign tick_o = run_i && ((ps_q & mask) == mask);

    // Phase counter: free-runs while running, held at zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)               ps_q <= '0;
        else if (clr_i || !run_i) ps_q <= '0;
        else                      ps_q <= ps_q + 1'b1;
    end

    AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i || clr_i) |=> (ps_q == '0)); // R4

endmodule

// File: rtl/cmp_tmr_core.sv
// Module: counter with compare matching and auto-clear shortcuts.
// Compares with a zero value are disabled. A zero task overrides ticks.
module cmp_tmr_core #(
    parameter int CNT_W  = 16,
    parameter int NUM_CC = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick_i,
    input  logic                         clr_i,
    input  logic [NUM_CC-1:0][CNT_W-1:0] cmp_val_i,
    input  logic [NUM_CC-1:0]            autoclr_i,
    output logic [CNT_W-1:0]             count_o,
    output logic [NUM_CC-1:0]            hit_o
);
    logic [CNT_W-1:0] count_q;
    logic             wrap;

    // Per-channel match detection on a tick
    for (genvar n = 0; n < NUM_CC; n++) begin : g_cmp
        assign hit_o[n] = tick_i && (cmp_val_i[n] != '0) && (count_q == cmp_val_i[n]);
    end

    assign wrap    = |(hit_o & autoclr_i);
    assign count_o = count_q;

    // Counter: zero task first, then tick with optional wrap
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (clr_i)  count_q <= '0;
        else if (tick_i) count_q <= wrap ? '0 : count_q + 1'b1;
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !tick_i) |=> $stable(count_q)); // R5
    AST_ZERO_TASK: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_q == '0)); // R6
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clr_i && wrap) |=> (count_q == '0)); // R7

endmodule

// File: rtl/cmp_timer.sv
// Module: top of the prescaled compare timer; register block and bus.
// Assumes a single-cycle bus: writes act on the edge where bus_sel and
// bus_we are high; read data is registered and valid the next cycle.
module cmp_timer
    import cmp_tmr_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_CC  = 4,
    parameter int DIV_MAX = 9,
    parameter int ADDR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int DIV_W     = $clog2(DIV_MAX + 1);
    localparam int FLAG_BASE = MATCH_BASE + NUM_CC;

    logic                         wr, rd, is_ctl;
    ctl_reg_e                     ctl_id;
    logic                         run_q;
    logic [DIV_W-1:0]             div_q;
    logic [NUM_CC-1:0]            autoclr_q, ien_q, flag_q, hit;
    logic [NUM_CC-1:0][CNT_W-1:0] cc_q;
    logic [NUM_CC-1:0]            cc_wr, flag_wr;
    logic                         zero_task, tick;
    logic [CNT_W-1:0]             count, rd_mux;

    assign wr        = bus_sel && bus_we;
    assign rd        = bus_sel && !bus_we;
    assign is_ctl    = bus_addr < ADDR_W'(MATCH_BASE);
    assign ctl_id    = ctl_reg_e'(bus_addr[2:0]);
    assign zero_task = wr && is_ctl && (ctl_id == RG_ZERO) && bus_wdata[0];

    // Run state from start/halt task strobes
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else if (wr && is_ctl && bus_wdata[0]) begin
            if (ctl_id == RG_RUN)       run_q <= 1'b1;
            else if (ctl_id == RG_HALT) run_q <= 1'b0;
        end
    end

    // Divider setting, clamped to DIV_MAX on write
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else if (wr && is_ctl && ctl_id == RG_DIV)
            div_q <= (bus_wdata > CNT_W'(DIV_MAX)) ? DIV_W'(DIV_MAX) : bus_wdata[DIV_W-1:0];
    end

    // Auto-clear mask and interrupt enable set/clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            autoclr_q <= '0;
            ien_q     <= '0;
        end else if (wr && is_ctl) begin
            if (ctl_id == RG_AUTOCLR) autoclr_q <= bus_wdata[NUM_CC-1:0];
            if (ctl_id == RG_IEN_SET) ien_q <= ien_q | bus_wdata[NUM_CC-1:0];
            if (ctl_id == RG_IEN_CLR) ien_q <= ien_q & ~bus_wdata[NUM_CC-1:0];
        end
    end

    for (genvar n = 0; n < NUM_CC; n++) begin : g_ch
        assign cc_wr[n]   = wr && (bus_addr == ADDR_W'(MATCH_BASE + n));
        assign flag_wr[n] = wr && (bus_addr == ADDR_W'(FLAG_BASE + n)) && !bus_wdata[0];

        // Compare value register
        always_ff @(posedge clk) begin
            if (!rst_n)       cc_q[n] <= '0;
            else if (cc_wr[n]) cc_q[n] <= bus_wdata;
        end

        // Sticky event flag; a hardware match beats a software clear
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_q[n] <= 1'b0;
            else if (hit[n])     flag_q[n] <= 1'b1;
            else if (flag_wr[n]) flag_q[n] <= 1'b0;
        end

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[n] && !flag_wr[n]) |=> flag_q[n]); // R10
        AST_MATCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            hit[n] |=> flag_q[n]); // R12
    end

    cmp_tmr_prescale #(.DIV_MAX(DIV_MAX), .DIV_W(DIV_W)) u_prescale (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_q),
        .clr_i  (zero_task),
        .div_i  (div_q),
        .tick_o (tick)
    );

    cmp_tmr_core #(.CNT_W(CNT_W), .NUM_CC(NUM_CC)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .clr_i     (zero_task),
        .cmp_val_i (cc_q),
        .autoclr_i (autoclr_q),
        .count_o   (count),
        .hit_o     (hit)
    );

    // Read multiplexer over control, compare and flag registers
    always_comb begin
        rd_mux = '0;
        if (is_ctl) begin
            case (ctl_id)
                RG_COUNT:               rd_mux = count;
                RG_DIV:                 rd_mux = CNT_W'(div_q);
                RG_AUTOCLR:             rd_mux = CNT_W'(autoclr_q);
                RG_IEN_SET, RG_IEN_CLR: rd_mux = CNT_W'(ien_q);
                default:                rd_mux = '0;
            endcase
        end else begin
            for (int n = 0; n < NUM_CC; n++) begin
                if (bus_addr == ADDR_W'(MATCH_BASE + n)) rd_mux = cc_q[n];
                if (bus_addr == ADDR_W'(FLAG_BASE + n))  rd_mux = CNT_W'(flag_q[n]);
            end
        end
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)  bus_rdata <= '0;
        else if (rd) bus_rdata <= rd_mux;
    end

    assign irq = |(flag_q & ien_q);

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= DIV_W'(DIV_MAX)); // R3
    AST_IEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && is_ctl && ctl_id == RG_IEN_SET) |=> ((ien_q & $past(bus_wdata[NUM_CC-1:0])) == $past(bus_wdata[NUM_CC-1:0]))); // R9
    AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !tick); // R5

endmodule

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;
    localparam int A_RUN = 0, A_HALT = 1, A_ZERO = 2, A_COUNT = 3, A_DIV = 4,
                   A_AUTOCLR = 5, A_IEN_SET = 6, A_IEN_CLR = 7, A_MATCH = 8, A_FLAG = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    typedef struct { logic [15:0] exp; string tag; } item_t;
    item_t q[$];
    logic rd_seen = 1'b0;

    always #10 clk = ~clk;

    cmp_timer u_cmp_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Monitor: a read issued before an edge returns data after it
    always @(posedge clk) rd_seen <= bus_sel && !bus_we;

    always @(negedge clk) begin
        if (rd_seen && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (bus_rdata !== it.exp) begin
                errors++;
                $display("FAIL %s: read %0d expected %0d", it.tag, bus_rdata, it.exp);
            end
        end
    end

    // Tasks are called at a negedge; the access acts on the next posedge
    task automatic wr(input int a, input int d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = 16'(d);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int a, input int e, input string tag);
        item_t it;
        it.exp = 16'(e); it.tag = tag;
        q.push_back(it);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 5'(a);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s: irq %0b expected %0b", tag, irq, e);
        end
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    errors++;
                    $display("FAIL watchdog: run hung, actual running expected done");
                    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                    $finish;
                end
            end
        join_none

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(A_COUNT, 0, "R1 count");
        rd(A_DIV, 0, "R1 div");
        rd(A_AUTOCLR, 0, "R1 autoclr");
        rd(A_IEN_SET, 0, "R1 enables");
        rd(A_MATCH + 0, 0, "R1 compare0");
        rd(A_FLAG + 0, 0, "R1 flag0");
        chk_irq(1'b0, "R1 irq");

        // R2 divide by 4: 16 running edges give 4 ticks
        wr(A_DIV, 2);
        wr(A_RUN, 1);
        idle(15);
        wr(A_HALT, 1);
        rd(A_COUNT, 4, "R2 prescaled count");

        // R5 halted counter holds its value
        idle(6);
        rd(A_COUNT, 4, "R5 hold while halted");

        // R3 clamp
        wr(A_DIV, 15);
        rd(A_DIV, 9, "R3 clamp");

        // R4 divider phase reset on halt
        wr(A_ZERO, 1);
        wr(A_DIV, 2);
        wr(A_RUN, 1);
        idle(5);
        wr(A_HALT, 1);
        rd(A_COUNT, 1, "R4 first run");
        wr(A_RUN, 1);
        idle(1);
        wr(A_HALT, 1);
        rd(A_COUNT, 1, "R4 no early tick after restart");

        // R5 full-rate counting
        wr(A_ZERO, 1);
        wr(A_DIV, 0);
        wr(A_RUN, 1);
        idle(9);
        wr(A_HALT, 1);
        rd(A_COUNT, 10, "R5 ten ticks");
        wr(A_RUN, 0);
        idle(2);
        rd(A_COUNT, 10, "R5 start with bit0 clear ignored");

        // R6 zero task wins over a tick on the same edge
        wr(A_RUN, 1);
        idle(2);
        wr(A_ZERO, 1);
        wr(A_HALT, 1);
        rd(A_COUNT, 1, "R6 zero beats tick");

        // R7 period of 5 with auto-clear on compare0 = 4
        wr(A_ZERO, 1);
        wr(A_MATCH + 0, 4);
        wr(A_AUTOCLR, 1);
        wr(A_RUN, 1);
        idle(11);
        wr(A_HALT, 1);
        rd(A_COUNT, 2, "R7 wrapped count");
        rd(A_FLAG + 0, 1, "R7 flag0 set");
        rd(A_FLAG + 1, 0, "R8 zero compare silent");

        // R9 enable set/clear
        wr(A_IEN_SET, 1);
        chk_irq(1'b1, "R11 irq from flag0");
        wr(A_IEN_SET, 4);
        rd(A_IEN_CLR, 5, "R9 mask via clear address");
        wr(A_IEN_SET, 0);
        rd(A_IEN_SET, 5, "R9 zero bits no change");
        wr(A_IEN_CLR, 1);
        chk_irq(1'b0, "R11 irq masked");
        rd(A_IEN_SET, 4, "R9 clear bit0");

        // R10 sticky flag cleared by writing 0
        wr(A_FLAG + 0, 1);
        rd(A_FLAG + 0, 1, "R10 write 1 keeps flag");
        wr(A_FLAG + 0, 0);
        rd(A_FLAG + 0, 0, "R10 flag cleared");

        // R12 match on compare2 collides with software clear
        wr(A_ZERO, 1);
        wr(A_MATCH + 2, 3);
        wr(A_RUN, 1);
        idle(3);
        wr(A_FLAG + 2, 0);
        wr(A_HALT, 1);
        rd(A_FLAG + 2, 1, "R12 match beats clear");
        chk_irq(1'b1, "R11 irq from flag2");
        wr(A_FLAG + 2, 0);
        rd(A_FLAG + 2, 0, "R10 flag2 cleared");
        chk_irq(1'b0, "R11 irq low");

        idle(3);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule